// File: doc/BRIEF.md
# Page Protection and Fault Encoder

This block decides whether one memory access of a 32-bit segmented, hashed-page translation unit may proceed. For each request it gets the access kind (load, store or instruction fetch), the privilege state, both translation-enable flags, the effective address, the sixteen segment registers, and the results of the block-translation and page-table lookups, which are done elsewhere. From the selected segment it picks a protection key, decodes the 2-bit page-protection code into read, write and execute rights, and compares them with the right that the access needs.

One cycle after a request, the block reports either a grant with the rights and the real address, or a fault. A fault sets a held record: instruction or data class, a fixed 32-bit status word for each cause, and the faulting address for data faults. The record stays until the consumer acknowledges it. When translation is off for the access kind, the block passes the effective address through with full rights.

Top module: `page_prot_fault_enc`

## Requirements
- R1: After reset, resp_valid, resp_grant, resp_fault, resp_rights, resp_raddr, fault_valid, fault_is_instr, fault_code and fault_addr are all zero.
- R2: The protection key is segment bit 29 when user_mode is 1, and segment bit 30 when user_mode is 0.
- R3: With key 0, page-protection codes 0, 1 and 2 give read and write, and code 3 gives read only. Rights are reported as bit 0 read, bit 1 write, bit 2 execute.
- R4: With key 1, code 0 gives no rights, codes 1 and 3 give read only, and code 2 gives read and write. A load needs read, a store needs write and a fetch needs execute. Access code 0 is a load, 1 a store, 2 a fetch, and 3 is treated as a load.
- R5: The execute right is granted from the page table only when segment bit 28 (no-execute) is 0. A translated fetch with no block hit from such a segment faults as an instruction fault with code 0x10000000. This check comes before the table-miss check.
- R6: A fetch with instr_xlate_on = 0, or a load or store with data_xlate_on = 0, is granted with rights 3'b111 and resp_raddr equal to eff_addr, whatever the other inputs are.
- R7: With translation on, a block hit takes precedence over the segment no-execute check and the page-table result. Its rights come from blk_rights and its real address from blk_raddr. A block denial uses the protection codes of R9.
- R8: A page-table miss gives code 0x40000000 for a fetch (instruction class) or for a load, and code 0x42000000 for a store.
- R9: A protection denial gives code 0x08000000 for a fetch (instruction class) or for a load, and code 0x0A000000 for a store. Data-class faults record eff_addr in fault_addr. Instruction-class faults record zero.
- R10: The segment register used is entry eff_addr[31:28] of seg_regs, and entry i occupies bits [32*i+31:32*i].
- R11: A fault record stays unchanged until fault_ack is 1 at a clock edge. While a record is pending and not acknowledged, a newer fault does not replace it. A fault arriving in the same cycle as the acknowledge is loaded.
- R12: Each request produces resp_valid for exactly one cycle, one cycle later, with exactly one of resp_grant or resp_fault set. On a fault, resp_rights and resp_raddr are zero. A page-table grant gives resp_raddr = {tbl_rpn, eff_addr[11:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| user_mode | input | 1 | 1 = problem (user) state |
| instr_xlate_on | input | 1 | Instruction translation enabled |
| data_xlate_on | input | 1 | Data translation enabled |
| eff_addr | input | 32 | Effective address |
| seg_regs | input | 512 | Sixteen 32-bit segment registers, entry i at bits 32*i |
| blk_hit | input | 1 | Block translation matched |
| blk_rights | input | 3 | Block rights {X,W,R} |
| blk_raddr | input | 32 | Block real address |
| tbl_hit | input | 1 | Page-table entry found |
| tbl_pp | input | 2 | Page-protection code of the found entry |
| tbl_rpn | input | 20 | Real page number of the found entry |
| fault_ack | input | 1 | Releases the held fault record |
| resp_valid | output | 1 | Result of the previous cycle's request |
| resp_grant | output | 1 | Access allowed |
| resp_fault | output | 1 | Access faulted |
| resp_rights | output | 3 | Granted rights {X,W,R} |
| resp_raddr | output | 32 | Real address on grant |
| fault_valid | output | 1 | Fault record pending |
| fault_is_instr | output | 1 | 1 = instruction-class fault |
| fault_code | output | 32 | Status word of the held fault |
| fault_addr | output | 32 | Faulting address (data faults) |

## Verification
Every combination of user_mode, segment key bits, page-protection code and access kind is run with the two key bits set to opposite values. A wrong key source or a wrong decode then changes the grant or fault outcome. Fetches from no-execute segments are run with a table miss present, which shows whether the no-execute check comes before the miss check. The same fetch with a block hit shows whether the block result comes first. Real-mode requests are sent with every other input set to fault, which shows that the bypass ignores them. Two segments with different keys under the same page-table entry show whether eff_addr[31:28] selects the entry. Back-to-back faults with and without an acknowledge show whether the held record is kept or replaced.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_ALT   = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      CAUSE_NONE = 2'd0,
      CAUSE_NX   = 2'd1,
      CAUSE_MISS = 2'd2,
      CAUSE_PROT = 2'd3
   } cause_e;

   localparam int RT_R = 0;
   localparam int RT_W = 1;
   localparam int RT_X = 2;

   localparam logic [31:0] ST_NX_FETCH  = 32'h1000_0000;
   localparam logic [31:0] ST_MISS_RD   = 32'h4000_0000;
   localparam logic [31:0] ST_MISS_WR   = 32'h4200_0000;
   localparam logic [31:0] ST_PROT_RD   = 32'h0800_0000;
   localparam logic [31:0] ST_PROT_WR   = 32'h0A00_0000;

   // right needed by an access kind, one-hot over {X,W,R}
   function automatic logic [2:0] needed_right(input logic [1:0] acc);
      case (acc)
         ACC_STORE: needed_right = 3'b010;
         ACC_FETCH: needed_right = 3'b100;
         default:   needed_right = 3'b001;
      endcase
   endfunction

endpackage

// File: rtl/pfe_seg_sel.sv
module pfe_seg_sel #(
   parameter int NUM_SEG   = 16,
   parameter int SEG_W     = 32,
   parameter int ADDR_W    = 32,
   parameter int KEY_S_BIT = 30,
   parameter int KEY_U_BIT = 29,
   parameter int NX_BIT    = 28
) (
   input  logic [NUM_SEG*SEG_W-1:0] seg_flat,
   input  logic [ADDR_W-1:0]        eff_addr,
   output logic                     key_sup,
   output logic                     key_usr,
   output logic                     seg_nx
);
   localparam int SEL_W = $clog2(NUM_SEG);

   generate
      if (NUM_SEG != (1 << SEL_W)) begin : g_bad_count
         $error("pfe_seg_sel: NUM_SEG must be a power of two");
      end
      if (KEY_S_BIT >= SEG_W || KEY_U_BIT >= SEG_W || NX_BIT >= SEG_W) begin : g_bad_bits
         $error("pfe_seg_sel: segment field position outside register");
      end
   endgenerate

   logic [SEG_W-1:0] seg_arr [NUM_SEG];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SEG; gi++) begin : g_unpack
         assign seg_arr[gi] = seg_flat[gi*SEG_W +: SEG_W];
      end
   endgenerate

   logic [SEL_W-1:0] sel;
   logic [SEG_W-1:0] seg_cur;

   assign sel     = eff_addr[ADDR_W-1 -: SEL_W];
   assign seg_cur = seg_arr[sel];

   assign key_sup = seg_cur[KEY_S_BIT];
   assign key_usr = seg_cur[KEY_U_BIT];
   assign seg_nx  = seg_cur[NX_BIT];

   logic unused_seg_bits;
   assign unused_seg_bits = ^seg_cur;

endmodule

// File: rtl/pfe_key_rights.sv
module pfe_key_rights #(
   parameter bit GATE_DECODE = 1'b0
) (
   input  logic       user_mode,
   input  logic       key_sup,
   input  logic       key_usr,
   input  logic       seg_nx,
   input  logic [1:0] pp,
   output logic       key,
   output logic [2:0] rights
);
   logic rd;
   logic wr;

   assign key = user_mode ? key_usr : key_sup;

   generate
      if (GATE_DECODE) begin : g_gate
         assign rd = key ? (|pp) : 1'b1;
         assign wr = key ? (pp == 2'b10) : ~(&pp);
      end else begin : g_table
         always_comb begin
            case ({key, pp})
               3'b000, 3'b001, 3'b010: begin rd = 1'b1; wr = 1'b1; end
               3'b011:                 begin rd = 1'b1; wr = 1'b0; end
               3'b100:                 begin rd = 1'b0; wr = 1'b0; end
               3'b110:                 begin rd = 1'b1; wr = 1'b1; end
               default:                begin rd = 1'b1; wr = 1'b0; end
            endcase
         end
      end
   endgenerate

   assign rights = {~seg_nx, wr, rd};

endmodule

// File: rtl/pfe_fault_enc.sv
module pfe_fault_enc
   import pfe_pkg::*;
(
   input  logic [1:0]  acc_type,
   input  logic        xlate_off,
   input  logic        blk_hit,
   input  logic [2:0]  blk_rights,
   input  logic        seg_nx,
   input  logic        tbl_hit,
   input  logic [2:0]  tbl_rights,
   output logic        grant,
   output logic        fault,
   output logic [2:0]  rights,
   output logic        is_instr,
   output logic [31:0] code
);
   logic [2:0] need;
   logic       is_fetch;
   logic       is_store;
   cause_e     cause;

   assign need     = needed_right(acc_type);
   assign is_fetch = (acc_type == ACC_FETCH);
   assign is_store = (acc_type == ACC_STORE);

   // priority: bypass, block, no-execute, miss, protection
   always_comb begin
      grant  = 1'b0;
      rights = 3'b000;
      cause  = CAUSE_NONE;
      if (xlate_off) begin
         grant  = 1'b1;
         rights = 3'b111;
      end else if (blk_hit) begin
         if ((need & ~blk_rights) != 3'b000) begin
            cause = CAUSE_PROT;
         end else begin
            grant  = 1'b1;
            rights = blk_rights;
         end
      end else if (is_fetch && seg_nx) begin
         cause = CAUSE_NX;
      end else if (!tbl_hit) begin
         cause = CAUSE_MISS;
      end else if ((need & ~tbl_rights) != 3'b000) begin
         cause = CAUSE_PROT;
      end else begin
         grant  = 1'b1;
         rights = tbl_rights;
      end
   end

   always_comb begin
      case (cause)
         CAUSE_NX:   code = ST_NX_FETCH;
         CAUSE_MISS: code = is_store ? ST_MISS_WR : ST_MISS_RD;
         CAUSE_PROT: code = is_store ? ST_PROT_WR : ST_PROT_RD;
         default:    code = 32'h0;
      endcase
   end

   assign fault    = (cause != CAUSE_NONE);
   assign is_instr = is_fetch;

endmodule

// File: rtl/pfe_fault_hold.sv
module pfe_fault_hold #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              fault_new,
   input  logic              new_is_instr,
   input  logic [31:0]       new_code,
   input  logic [ADDR_W-1:0] new_addr,
   input  logic              fault_ack,
   output logic              fault_valid,
   output logic              fault_is_instr,
   output logic [31:0]       fault_code,
   output logic [ADDR_W-1:0] fault_addr
);
   logic can_load;
   logic load_now;

   assign can_load = !fault_valid || fault_ack;
   assign load_now = can_load && req_valid && fault_new;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_valid    <= 1'b0;
         fault_is_instr <= 1'b0;
         fault_code     <= '0;
         fault_addr     <= '0;
      end else if (can_load) begin
         fault_valid <= load_now;
         if (load_now) begin
            fault_is_instr <= new_is_instr;
            fault_code     <= new_code;
            fault_addr     <= new_is_instr ? '0 : new_addr;
         end
      end
   end

   p_fault_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid && !fault_ack |=> fault_valid && $stable(fault_code)
                                    && $stable(fault_addr) && $stable(fault_is_instr));

   p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid && fault_ack && !(req_valid && fault_new) |=> !fault_valid);

endmodule

// File: rtl/page_prot_fault_enc.sv
module page_prot_fault_enc
   import pfe_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int PAGE_BITS   = 12,
   parameter int NUM_SEG     = 16,
   parameter int SEG_W       = 32,
   parameter int KEY_S_BIT   = 30,
   parameter int KEY_U_BIT   = 29,
   parameter int NX_BIT      = 28,
   parameter bit GATE_DECODE = 1'b0,
   localparam int RPN_W      = ADDR_W - PAGE_BITS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [1:0]               acc_type,
   input  logic                     user_mode,
   input  logic                     instr_xlate_on,
   input  logic                     data_xlate_on,
   input  logic [ADDR_W-1:0]        eff_addr,
   input  logic [NUM_SEG*SEG_W-1:0] seg_regs,
   input  logic                     blk_hit,
   input  logic [2:0]               blk_rights,
   input  logic [ADDR_W-1:0]        blk_raddr,
   input  logic                     tbl_hit,
   input  logic [1:0]               tbl_pp,
   input  logic [RPN_W-1:0]         tbl_rpn,
   input  logic                     fault_ack,
   output logic                     resp_valid,
   output logic                     resp_grant,
   output logic                     resp_fault,
   output logic [2:0]               resp_rights,
   output logic [ADDR_W-1:0]        resp_raddr,
   output logic                     fault_valid,
   output logic                     fault_is_instr,
   output logic [31:0]              fault_code,
   output logic [ADDR_W-1:0]        fault_addr
);
   generate
      if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_W) begin : g_bad_page
         $error("page_prot_fault_enc: PAGE_BITS out of range");
      end
   endgenerate

   logic        key_sup, key_usr, seg_nx, key;
   logic [2:0]  tbl_rights;
   logic        xlate_off;
   logic        grant_c, fault_c, instr_c;
   logic [2:0]  rights_c;
   logic [31:0] code_c;
   logic [ADDR_W-1:0] raddr_c;

   assign xlate_off = (acc_type == ACC_FETCH) ? !instr_xlate_on : !data_xlate_on;

   pfe_seg_sel #(
      .NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .ADDR_W(ADDR_W),
      .KEY_S_BIT(KEY_S_BIT), .KEY_U_BIT(KEY_U_BIT), .NX_BIT(NX_BIT)
   ) u_seg_sel (
      .seg_flat(seg_regs), .eff_addr(eff_addr),
      .key_sup(key_sup), .key_usr(key_usr), .seg_nx(seg_nx)
   );

   pfe_key_rights #(.GATE_DECODE(GATE_DECODE)) u_key_rights (
      .user_mode(user_mode), .key_sup(key_sup), .key_usr(key_usr),
      .seg_nx(seg_nx), .pp(tbl_pp), .key(key), .rights(tbl_rights)
   );

   pfe_fault_enc u_fault_enc (
      .acc_type(acc_type), .xlate_off(xlate_off), .blk_hit(blk_hit),
      .blk_rights(blk_rights), .seg_nx(seg_nx), .tbl_hit(tbl_hit),
      .tbl_rights(tbl_rights), .grant(grant_c), .fault(fault_c),
      .rights(rights_c), .is_instr(instr_c), .code(code_c)
   );

   always_comb begin
      if (xlate_off)    raddr_c = eff_addr;
      else if (blk_hit) raddr_c = blk_raddr;
      else              raddr_c = {tbl_rpn, eff_addr[PAGE_BITS-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid  <= 1'b0;
         resp_grant  <= 1'b0;
         resp_fault  <= 1'b0;
         resp_rights <= '0;
         resp_raddr  <= '0;
      end else begin
         resp_valid  <= req_valid;
         resp_grant  <= req_valid && grant_c;
         resp_fault  <= req_valid && fault_c;
         resp_rights <= (req_valid && grant_c) ? rights_c : '0;
         resp_raddr  <= (req_valid && grant_c) ? raddr_c : '0;
      end
   end

   pfe_fault_hold #(.ADDR_W(ADDR_W)) u_fault_hold (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fault_new(fault_c),
      .new_is_instr(instr_c), .new_code(code_c), .new_addr(eff_addr),
      .fault_ack(fault_ack), .fault_valid(fault_valid),
      .fault_is_instr(fault_is_instr), .fault_code(fault_code),
      .fault_addr(fault_addr)
   );

   p_real_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && xlate_off |=> resp_grant && (resp_rights == 3'b111)
                                 && (resp_raddr == $past(eff_addr)));

   p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (resp_grant != resp_fault));

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_valid |-> !resp_grant && !resp_fault);

   p_nx_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (acc_type == ACC_FETCH) && instr_xlate_on && !blk_hit && seg_nx
      && (!fault_valid || fault_ack)
      |=> fault_valid && fault_is_instr && (fault_code == ST_NX_FETCH));

   p_key1_pp0_deny_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (acc_type == ACC_LOAD) && data_xlate_on && !blk_hit
      && tbl_hit && key && (tbl_pp == 2'b00) |=> resp_fault);

endmodule

// File: tb/page_prot_fault_enc_tb.sv
`timescale 1ns/1ps
module page_prot_fault_enc_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, user_mode, instr_xlate_on, data_xlate_on;
   logic [1:0]  acc_type;
   logic [31:0] eff_addr;
   logic [31:0] segs [16];
   logic [511:0] seg_flat;
   logic        blk_hit, tbl_hit, fault_ack;
   logic [2:0]  blk_rights;
   logic [31:0] blk_raddr;
   logic [1:0]  tbl_pp;
   logic [19:0] tbl_rpn;
   logic        resp_valid, resp_grant, resp_fault, fault_valid, fault_is_instr;
   logic [2:0]  resp_rights;
   logic [31:0] resp_raddr, fault_code, fault_addr;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 16; i++) seg_flat[i*32 +: 32] = segs[i];
   end

   page_prot_fault_enc u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_type(acc_type),
      .user_mode(user_mode), .instr_xlate_on(instr_xlate_on),
      .data_xlate_on(data_xlate_on), .eff_addr(eff_addr), .seg_regs(seg_flat),
      .blk_hit(blk_hit), .blk_rights(blk_rights), .blk_raddr(blk_raddr),
      .tbl_hit(tbl_hit), .tbl_pp(tbl_pp), .tbl_rpn(tbl_rpn), .fault_ack(fault_ack),
      .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_fault(resp_fault),
      .resp_rights(resp_rights), .resp_raddr(resp_raddr), .fault_valid(fault_valid),
      .fault_is_instr(fault_is_instr), .fault_code(fault_code), .fault_addr(fault_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_seg(input logic ks, input logic ku, input logic nx);
      return {1'b0, ks, ku, nx, 28'h0ABCDE0};
   endfunction

   // expected outcome from the requirements
   logic        e_grant, e_instr;
   logic [2:0]  e_rights;
   logic [31:0] e_raddr, e_code, e_faddr;

   task automatic model();
      logic fetch, store, off, key, nx, rd, wr;
      logic [31:0] sr;
      logic [2:0] need, tr;
      fetch = (acc_type == 2'd2);
      store = (acc_type == 2'd1);
      need  = fetch ? 3'b100 : (store ? 3'b010 : 3'b001);
      off   = fetch ? !instr_xlate_on : !data_xlate_on;
      sr    = segs[eff_addr[31:28]];
      key   = user_mode ? sr[29] : sr[30];
      nx    = sr[28];
      rd    = key ? (tbl_pp != 2'd0) : 1'b1;
      wr    = key ? (tbl_pp == 2'd2) : (tbl_pp != 2'd3);
      tr    = {!nx, wr, rd};
      e_grant = 1'b0; e_rights = 3'b000; e_raddr = 32'h0; e_code = 32'h0;
      e_instr = fetch;
      if (off) begin
         e_grant = 1'b1; e_rights = 3'b111; e_raddr = eff_addr;
      end else if (blk_hit) begin
         if ((need & ~blk_rights) != 0) e_code = store ? 32'h0A00_0000 : 32'h0800_0000;
         else begin e_grant = 1'b1; e_rights = blk_rights; e_raddr = blk_raddr; end
      end else if (fetch && nx) begin
         e_code = 32'h1000_0000;
      end else if (!tbl_hit) begin
         e_code = store ? 32'h4200_0000 : 32'h4000_0000;
      end else if ((need & ~tr) != 0) begin
         e_code = store ? 32'h0A00_0000 : 32'h0800_0000;
      end else begin
         e_grant = 1'b1; e_rights = tr; e_raddr = {tbl_rpn, eff_addr[11:0]};
      end
      e_faddr = fetch ? 32'h0 : eff_addr;
   endtask

   task automatic issue(input logic ack_same);
      @(negedge clk);
      req_valid = 1'b1;
      fault_ack = ack_same;
      @(negedge clk);
      req_valid = 1'b0;
      fault_ack = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk);
      fault_ack = 1'b1;
      @(negedge clk);
      fault_ack = 1'b0;
      chk("R11 ack clears", {31'b0, fault_valid}, 32'h0);
   endtask

   task automatic run_check(input string tag);
      model();
      issue(1'b0);
      chk({tag, " R12 valid"}, {31'b0, resp_valid}, 32'h1);
      chk({tag, " grant"}, {31'b0, resp_grant}, {31'b0, e_grant});
      chk({tag, " R12 fault"}, {31'b0, resp_fault}, {31'b0, !e_grant});
      chk({tag, " rights"}, {29'b0, resp_rights}, {29'b0, e_rights});
      chk({tag, " raddr"}, resp_raddr, e_raddr);
      chk({tag, " fault_valid"}, {31'b0, fault_valid}, {31'b0, !e_grant});
      if (!e_grant) begin
         chk({tag, " code"}, fault_code, e_code);
         chk({tag, " class"}, {31'b0, fault_is_instr}, {31'b0, e_instr});
         chk({tag, " R9 addr"}, fault_addr, e_faddr);
         do_ack();
      end
   endtask

   task automatic set_defaults();
      req_valid = 0; fault_ack = 0; acc_type = 0; user_mode = 0;
      instr_xlate_on = 1; data_xlate_on = 1; eff_addr = 32'h3000_1234;
      blk_hit = 0; blk_rights = 0; blk_raddr = 32'h0; tbl_hit = 1;
      tbl_pp = 2'd2; tbl_rpn = 20'h5A5A5;
      for (int i = 0; i < 16; i++) segs[i] = mk_seg(1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1 resp_valid", {31'b0, resp_valid}, 32'h0);
      chk("R1 resp_grant", {31'b0, resp_grant}, 32'h0);
      chk("R1 resp_fault", {31'b0, resp_fault}, 32'h0);
      chk("R1 resp_raddr", resp_raddr, 32'h0);
      chk("R1 fault_valid", {31'b0, fault_valid}, 32'h0);
      chk("R1 fault_code", fault_code, 32'h0);
      chk("R1 fault_addr", fault_addr, 32'h0);
   endtask

   task automatic t_sweep();
      eff_addr = 32'h3000_0ABC;
      for (int u = 0; u < 2; u++)
         for (int k = 0; k < 2; k++)
            for (int p = 0; p < 4; p++)
               for (int a = 0; a < 4; a++) begin
                  user_mode = u[0];
                  segs[3] = mk_seg(k[0], !k[0], 1'b0);
                  tbl_pp = p[1:0];
                  acc_type = a[1:0];
                  run_check("R2/R3/R4 sweep");
               end
      segs[3] = mk_seg(1'b0, 1'b0, 1'b0);
      user_mode = 0;
   endtask

   task automatic t_nx();
      segs[3] = mk_seg(1'b0, 1'b0, 1'b1);
      acc_type = 2'd2; tbl_hit = 0;
      run_check("R5 nx before miss");
      chk("R5 code", e_code, 32'h1000_0000);
      tbl_hit = 1;
      run_check("R5 nx fetch");
      acc_type = 2'd0;
      run_check("R5 nx load ok");
      segs[3] = mk_seg(1'b0, 1'b0, 1'b0);
      acc_type = 2'd2;
      run_check("R5 exec clear");
   endtask

   task automatic t_real();
      segs[3] = mk_seg(1'b1, 1'b1, 1'b1);
      tbl_hit = 0; tbl_pp = 0; blk_hit = 1; blk_rights = 3'b000;
      eff_addr = 32'h3777_8123;
      acc_type = 2'd2; instr_xlate_on = 0;
      run_check("R6 fetch real");
      acc_type = 2'd1; instr_xlate_on = 0; data_xlate_on = 1;
      run_check("R6 store translated");
      data_xlate_on = 0;
      run_check("R6 store real");
      acc_type = 2'd2; instr_xlate_on = 1;
      run_check("R6 fetch translated");
      instr_xlate_on = 1; data_xlate_on = 1; blk_hit = 0; tbl_hit = 1;
      segs[3] = mk_seg(1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_block();
      blk_hit = 1; blk_raddr = 32'h8000_0000; tbl_hit = 0;
      segs[3] = mk_seg(1'b1, 1'b1, 1'b1);
      blk_rights = 3'b101; acc_type = 2'd0;
      run_check("R7 block load");
      acc_type = 2'd2;
      run_check("R7 block beats nx");
      acc_type = 2'd1;
      run_check("R7 block store deny");
      chk("R7 code", e_code, 32'h0A00_0000);
      blk_rights = 3'b001; acc_type = 2'd2;
      run_check("R7 block fetch deny");
      blk_hit = 0; tbl_hit = 1; segs[3] = mk_seg(1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_miss();
      tbl_hit = 0;
      for (int a = 0; a < 3; a++) begin
         acc_type = a[1:0];
         eff_addr = 32'h3000_0100 + a;
         run_check("R8 miss");
      end
      tbl_hit = 1;
   endtask

   task automatic t_segsel();
      segs[5] = mk_seg(1'b1, 1'b0, 1'b0);
      segs[6] = mk_seg(1'b0, 1'b1, 1'b0);
      tbl_pp = 2'd0; acc_type = 2'd0; user_mode = 0;
      eff_addr = 32'h5000_0040;
      run_check("R10 seg5");
      chk("R10 seg5 denies", {31'b0, e_grant}, 32'h0);
      eff_addr = 32'h6000_0040;
      run_check("R10 seg6");
      chk("R10 seg6 grants", {31'b0, e_grant}, 32'h1);
      tbl_pp = 2'd2;
   endtask

   task automatic t_hold();
      tbl_hit = 0; acc_type = 2'd0; eff_addr = 32'h3000_0AA0;
      issue(1'b0);
      acc_type = 2'd1; eff_addr = 32'h3000_0BB0;
      issue(1'b0);
      chk("R11 second resp_fault", {31'b0, resp_fault}, 32'h1);
      chk("R11 held code", fault_code, 32'h4000_0000);
      chk("R11 held addr", fault_addr, 32'h3000_0AA0);
      issue(1'b1);
      chk("R11 replaced on ack", fault_code, 32'h4200_0000);
      chk("R11 new addr", fault_addr, 32'h3000_0BB0);
      do_ack();
      tbl_hit = 1;
   endtask

   initial begin
      set_defaults();
      rst_n = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      t_sweep();
      t_nx();
      t_real();
      t_block();
      t_miss();
      t_segsel();
      t_hold();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #800000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule